// File: doc/BRIEF.md
# Two-Channel Calendar Alarm Matcher

This block watches a running BCD calendar (seconds, minutes, hours, date, month, weekday) and compares it with two programmed alarm settings. The first alarm can compare up to six fields. The second alarm compares minutes, hours and one extra field, which software configures as either a date or a weekday. Every field has its own compare-enable, so software can build alarms such as "every hour at minute 15" or "each Tuesday at 07:30".

The compare is evaluated only on the once-per-second tick supplied by the timekeeping logic. A match sets a sticky flag, provided that alarm is enabled globally. The flags stay set until software clears them. A registered interrupt request is raised while any flag is set and interrupts are enabled. Registers are written through a simple single-cycle write port. Shaping of the interrupt pin is left to surrounding logic.

Top module: `alarm_match_unit`

## Requirements
- R1: In the cycle after a synchronous reset, both flags and the interrupt are 0, and all alarm and control registers are 0.
- R2: When alarm 1's enabled fields all equal the current time on a tick, and alarm 1 is globally enabled, `a1_flag` is 1 from the cycle after the tick.
- R3: Bit 7 of each alarm register is that field's compare-enable. A field with bit 7 clear is ignored, and a set field that differs prevents the match.
- R4: An alarm with none of its field enables set never raises its flag.
- R5: Alarm 2's third register (address 8) uses bit 6 as its compare-enable. Bit 7 selects the mode: 1 compares bits 2:0 with the weekday, and 0 compares bits 5:0 with the date.
- R6: Flags rise only in the cycle after a tick. A match held for many cycles without a tick sets nothing.
- R7: Control register (address 9) bit 0 gates alarm 1, bit 1 gates alarm 2, and bit 2 enables the interrupt. A gated-off alarm never sets its flag.
- R8: Flags are sticky. A write to address 10 clears flag 1 when data bit 0 is 0 and flag 2 when data bit 1 is 0. A 1 in a bit leaves that flag alone. If a set and a clear fall in the same cycle, the set wins.
- R9: `irq` is 1 exactly one cycle after `ctrl[2]` is 1 and either flag is 1, and 0 otherwise.
- R10: Addresses 0 to 5 hold alarm 1's seconds, minutes, hours, date, month and weekday. Addresses 6 to 8 hold alarm 2's minutes, hours and date/weekday. Compare widths are 7 bits for seconds and minutes, 6 bits for hours and date, 5 bits for month and 3 bits for weekday.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse once per second |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_date | input | 6 | Current date, BCD |
| cur_month | input | 5 | Current month, BCD |
| cur_wday | input | 3 | Current weekday 0 to 6 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Write data |
| a1_flag | output | 1 | Alarm 1 sticky flag |
| a2_flag | output | 1 | Alarm 2 sticky flag |
| irq | output | 1 | Registered interrupt request |

## Verification
A corrupted alarm register or a lost field enable does not show up until the next tick that should match, or should not match. At that point the flag is wrong one cycle after the tick, and `irq` is wrong one cycle after that. A flag that drops without a clear, or a gating bit that is ignored, appears on the very next edge. For this reason the bench compares both flags and `irq` with a behavioural model on every clock, across tick, write and clear patterns that hit each field and mode.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int VAL_W     = 7;
  localparam int A1_FIELDS = 6;
  localparam int A2_FIELDS = 3;
  localparam int A1_BASE   = 0;
  localparam int A2_BASE   = 6;
  localparam int CTRL_ADDR = 9;
  localparam int STAT_ADDR = 10;

  typedef struct packed {
    logic irq_en;
    logic a2_en;
    logic a1_en;
  } ctrl_t;

  function automatic logic [VAL_W-1:0] a1_mask(input int idx);
    case (idx)
      0, 1:    return 7'h7f;
      2, 3:    return 7'h3f;
      4:       return 7'h1f;
      default: return 7'h07;
    endcase
  endfunction
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int W = 7
) (
  input  logic         use_i,
  input  logic [W-1:0] ref_i,
  input  logic [W-1:0] cur_i,
  output logic         ok_o
);
  assign ok_o = !use_i || (ref_i == cur_i);
endmodule

// File: rtl/alarm_set_match.sv
module alarm_set_match #(
  parameter int NF = 3,
  parameter int W  = 7
) (
  input  logic [NF-1:0]        use_i,
  input  logic [NF-1:0][W-1:0] ref_i,
  input  logic [NF-1:0][W-1:0] cur_i,
  output logic                 match_o
);
  logic [NF-1:0] ok;

  for (genvar i = 0; i < NF; i++) begin : g_field
    alarm_field_cmp #(.W(W)) u_cmp (
      .use_i (use_i[i]),
      .ref_i (ref_i[i]),
      .cur_i (cur_i[i]),
      .ok_o  (ok[i])
    );
  end

  assign match_o = (|use_i) && (&ok);
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [6:0]        cur_sec,
  input  logic [6:0]        cur_min,
  input  logic [5:0]        cur_hour,
  input  logic [5:0]        cur_date,
  input  logic [4:0]        cur_month,
  input  logic [2:0]        cur_wday,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              a1_flag,
  output logic              a2_flag,
  output logic              irq
);
  localparam int EN_BIT = DATA_W - 1;

  logic [DATA_W-1:0] a1_q [A1_FIELDS];
  logic [DATA_W-1:0] a2_q [A2_FIELDS];
  ctrl_t             ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < A1_FIELDS; i++) a1_q[i] <= '0;
      for (int i = 0; i < A2_FIELDS; i++) a2_q[i] <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < A1_FIELDS; i++)
        if (wr_addr == ADDR_W'(A1_BASE + i)) a1_q[i] <= wr_data;
      for (int i = 0; i < A2_FIELDS; i++)
        if (wr_addr == ADDR_W'(A2_BASE + i)) a2_q[i] <= wr_data;
      if (wr_addr == ADDR_W'(CTRL_ADDR)) ctrl_q <= ctrl_t'(wr_data[2:0]);
    end
  end

  logic [A1_FIELDS-1:0]            use1;
  logic [A1_FIELDS-1:0][VAL_W-1:0] ref1, cur1;
  logic [A2_FIELDS-1:0]            use2;
  logic [A2_FIELDS-1:0][VAL_W-1:0] ref2, cur2;
  logic                            wday_mode;

  assign cur1[0] = cur_sec;
  assign cur1[1] = cur_min;
  assign cur1[2] = {1'b0, cur_hour};
  assign cur1[3] = {1'b0, cur_date};
  assign cur1[4] = {2'b0, cur_month};
  assign cur1[5] = {4'b0, cur_wday};

  for (genvar i = 0; i < A1_FIELDS; i++) begin : g_a1
    assign ref1[i] = a1_q[i][VAL_W-1:0] & a1_mask(i);
    assign use1[i] = a1_q[i][EN_BIT];
  end

  assign wday_mode = a2_q[2][EN_BIT];
  assign use2      = {a2_q[2][EN_BIT-1], a2_q[1][EN_BIT], a2_q[0][EN_BIT]};
  assign ref2[0]   = a2_q[0][VAL_W-1:0];
  assign ref2[1]   = a2_q[1][VAL_W-1:0] & 7'h3f;
  assign ref2[2]   = wday_mode ? {4'b0, a2_q[2][2:0]} : {1'b0, a2_q[2][5:0]};
  assign cur2[0]   = cur_min;
  assign cur2[1]   = {1'b0, cur_hour};
  assign cur2[2]   = wday_mode ? {4'b0, cur_wday} : {1'b0, cur_date};

  logic m1, m2;

  alarm_set_match #(.NF(A1_FIELDS), .W(VAL_W)) u_set1 (
    .use_i (use1), .ref_i (ref1), .cur_i (cur1), .match_o (m1)
  );
  alarm_set_match #(.NF(A2_FIELDS), .W(VAL_W)) u_set2 (
    .use_i (use2), .ref_i (ref2), .cur_i (cur2), .match_o (m2)
  );

  logic stat_wr;
  assign stat_wr = wr_en && (wr_addr == ADDR_W'(STAT_ADDR));

  alarm_flag_ctrl u_flag1 (
    .clk    (clk),
    .rst    (rst),
    .set_i  (tick && ctrl_q.a1_en && m1),
    .clr_i  (stat_wr && !wr_data[0]),
    .flag_o (a1_flag)
  );
  alarm_flag_ctrl u_flag2 (
    .clk    (clk),
    .rst    (rst),
    .set_i  (tick && ctrl_q.a2_en && m2),
    .clr_i  (stat_wr && !wr_data[1]),
    .flag_o (a2_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ctrl_q.irq_en && (a1_flag || a2_flag);
  end
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [2:0]        ctrl_bits,
  input logic              a1_flag,
  input logic              a2_flag,
  input logic              irq
);
  logic clr1, clr2;
  assign clr1 = wr_en && (wr_addr == ADDR_W'(alarm_pkg::STAT_ADDR)) && !wr_data[0];
  assign clr2 = wr_en && (wr_addr == ADDR_W'(alarm_pkg::STAT_ADDR)) && !wr_data[1];

  AST_A1_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst) $rose(a1_flag) |-> $past(tick)); // R6
  AST_A2_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst) $rose(a2_flag) |-> $past(tick)); // R6
  AST_A1_GATED: assert property (@(posedge clk) disable iff (rst) $rose(a1_flag) |-> $past(ctrl_bits[0])); // R7
  AST_A2_GATED: assert property (@(posedge clk) disable iff (rst) $rose(a2_flag) |-> $past(ctrl_bits[1])); // R7
  AST_A1_STICKY: assert property (@(posedge clk) disable iff (rst) (a1_flag && !clr1) |=> a1_flag); // R8
  AST_A2_STICKY: assert property (@(posedge clk) disable iff (rst) (a2_flag && !clr2) |=> a2_flag); // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst) irq |-> ($past(ctrl_bits[2]) && $past(a1_flag || a2_flag))); // R9
endmodule

bind alarm_match_unit alarm_match_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .ctrl_bits (ctrl_q),
  .a1_flag   (a1_flag),
  .a2_flag   (a2_flag),
  .irq       (irq)
);

// File: tb/tb_alarm_match_unit.sv
module tb_alarm_match_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [6:0] cur_sec = '0, cur_min = '0;
  logic [5:0] cur_hour = '0, cur_date = '0;
  logic [4:0] cur_month = '0;
  logic [2:0] cur_wday = '0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       a1_flag, a2_flag, irq;

  int    n_chk = 0, n_err = 0, cycles = 0;
  bit    done = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  alarm_match_unit dut (
    .clk(clk), .rst(rst), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .cur_month(cur_month), .cur_wday(cur_wday),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .a1_flag(a1_flag), .a2_flag(a2_flag), .irq(irq)
  );

  // behavioural reference model
  int m_a1[6], m_a2[3], m_ctrl;
  bit m_f1, m_f2, m_irq;
  int mk[6] = '{'h7f, 'h7f, 'h3f, 'h3f, 'h1f, 'h07};

  function automatic bit mdl_m1();
    int cv[6];
    int n = 0;
    bit ok = 1;
    cv = '{int'(cur_sec), int'(cur_min), int'(cur_hour), int'(cur_date), int'(cur_month), int'(cur_wday)};
    for (int i = 0; i < 6; i++)
      if (m_a1[i] & 'h80) begin
        n++;
        if ((m_a1[i] & mk[i]) != (cv[i] & mk[i])) ok = 0;
      end
    return (n > 0) && ok;
  endfunction

  function automatic bit mdl_m2();
    int n = 0;
    bit ok = 1;
    if (m_a2[0] & 'h80) begin n++; if ((m_a2[0] & 'h7f) != int'(cur_min)) ok = 0; end
    if (m_a2[1] & 'h80) begin n++; if ((m_a2[1] & 'h3f) != int'(cur_hour)) ok = 0; end
    if (m_a2[2] & 'h40) begin
      n++;
      if (m_a2[2] & 'h80) begin if ((m_a2[2] & 7) != int'(cur_wday)) ok = 0; end
      else if ((m_a2[2] & 'h3f) != int'(cur_date)) ok = 0;
    end
    return (n > 0) && ok;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_a1[i]) m_a1[i] = 0;
      foreach (m_a2[i]) m_a2[i] = 0;
      m_ctrl = 0; m_f1 = 0; m_f2 = 0; m_irq = 0;
    end else begin
      bit s1, s2, c1, c2;
      s1 = tick && m_ctrl[0] && mdl_m1();
      s2 = tick && m_ctrl[1] && mdl_m2();
      c1 = wr_en && wr_addr == 10 && !wr_data[0];
      c2 = wr_en && wr_addr == 10 && !wr_data[1];
      m_irq = m_ctrl[2] && (m_f1 || m_f2);
      m_f1 = s1 || (m_f1 && !c1);
      m_f2 = s2 || (m_f2 && !c2);
      if (wr_en) begin
        if (wr_addr < 6) m_a1[wr_addr] = wr_data;
        else if (wr_addr < 9) m_a2[wr_addr - 6] = wr_data;
        else if (wr_addr == 9) m_ctrl = wr_data & 7;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({phase, " model a1_flag"}, a1_flag, m_f1);
      chk({phase, " model a2_flag"}, a2_flag, m_f2);
      chk({phase, " model irq"}, irq, m_irq);
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse();
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic set_time(input int s, input int m, input int h, input int d, input int mo, input int w);
    cur_sec = 7'(s); cur_min = 7'(m); cur_hour = 6'(h);
    cur_date = 6'(d); cur_month = 5'(mo); cur_wday = 3'(w);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 a1_flag after reset", a1_flag, 0);
    chk("R1 a2_flag after reset", a2_flag, 0);
    chk("R1 irq after reset", irq, 0);

    phase = "R4";
    wr(9, 7);
    set_time(0, 0, 0, 0, 0, 0);
    pulse();
    chk("R4 no fields enabled a1", a1_flag, 0);
    chk("R4 no fields enabled a2", a2_flag, 0);

    phase = "R2";
    wr(0, 'hb0); wr(1, 'h95);
    set_time('h30, 'h15, 'h08, 'h21, 'h07, 2);
    pulse();
    chk("R2 alarm1 fires", a1_flag, 1);
    @(negedge clk);
    chk("R9 irq follows flag", irq, 1);

    phase = "R8";
    wr(10, 'h02);
    chk("R8 clear flag1", a1_flag, 0);
    @(negedge clk);
    chk("R9 irq drops", irq, 0);

    phase = "R6";
    repeat (5) @(negedge clk);
    chk("R6 no tick no flag", a1_flag, 0);

    phase = "R3";
    wr(2, 'h05);
    set_time('h30, 'h15, 'h11, 'h21, 'h07, 2);
    pulse();
    chk("R3 disabled hour ignored", a1_flag, 1);
    wr(10, 'h02);
    wr(2, 'h85);
    pulse();
    chk("R3 enabled hour mismatch", a1_flag, 0);
    set_time('h30, 'h15, 'h05, 'h21, 'h07, 2);
    wr(4, 'h87);
    pulse();
    chk("R10 hour and month fields match", a1_flag, 1);
    wr(10, 'h02);
    wr(4, 'h89);
    pulse();
    chk("R10 month mismatch", a1_flag, 0);

    phase = "R5";
    wr(6, 'hc5); wr(8, 'hc3);
    set_time(0, 'h45, 'h05, 'h19, 'h07, 3);
    pulse();
    chk("R5 weekday mode fires", a2_flag, 1);
    chk("R5 alarm1 untouched", a1_flag, 0);
    wr(10, 'h01);
    chk("R8 clear flag2", a2_flag, 0);
    wr(8, 'h59);
    set_time(0, 'h45, 'h05, 'h19, 'h07, 5);
    pulse();
    chk("R5 date mode fires", a2_flag, 1);
    wr(10, 'h01);
    set_time(0, 'h45, 'h05, 'h20, 'h07, 5);
    pulse();
    chk("R5 date mismatch", a2_flag, 0);

    phase = "R7";
    set_time(0, 'h45, 'h05, 'h19, 'h07, 5);
    wr(9, 5);
    pulse();
    chk("R7 alarm2 gated off", a2_flag, 0);

    phase = "R8";
    wr(9, 7);
    tick = 1; wr_en = 1; wr_addr = 4'd10; wr_data = 8'h00;
    @(negedge clk);
    tick = 0; wr_en = 0;
    chk("R8 set beats clear", a2_flag, 1);
    wr(10, 'h03);
    chk("R8 writing ones keeps flag", a2_flag, 1);

    phase = "R9";
    wr(9, 3);
    @(negedge clk);
    chk("R9 irq disabled", irq, 0);
    wr(9, 7);
    @(negedge clk);
    chk("R9 irq enabled", irq, 1);

    @(negedge clk);
    finish_run();
  end
endmodule